// File: doc/BRIEF.md
# Phase/Frequency Comparator with Lock Flag

This block sits in a frequency-synthesis loop. It compares a feedback pulse train against a reference rate. The feedback train comes from an external programmable divider that follows a VCO. The reference is made inside the block by dividing the crystal clock down to one of two comparison rates, and `rate_sel` chooses which.

The comparator is edge triggered and has two pending flags, one for "raise" and one for "lower". The first rising edge to arrive, reference or feedback, sets its own flag. When the other edge arrives, both flags clear. A pending raise drives the steering output high, and a pending lower drives it low. With neither flag pending, the steering output is released, which is shown by its enable going low. The lock flag sits high and falls only while a flag is pending, so a locked loop shows a steady high and a loop out of lock shows short low pulses.

The block also gives the crystal clock divided by two on a separate pin. For example, a 10.24 MHz crystal gives 5.12 MHz on that pin and either a 10 kHz or a 5 kHz reference. All logic runs on the crystal clock. Both edge sources pass through two-flop synchronisers and an edge detector before they reach the comparator. The block carries no data stream, so it has no valid/ready interface, and every pin is plain control or status.

Top module: `pfd_lock_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `phase_oe` = 0, `lock_ok` = 1, `half_clk` = 0, and the prescaler count is held at 0.
- R2: `half_clk` is 0 just after reset release, becomes 1 after the first rising clock edge, and then toggles on every rising clock edge.
- R3: With `rate_sel` = 1 the reference period is 2^DIV_FAST_LOG2 (1024) clock cycles, and its first rising edge follows the 512th rising clock edge after reset release. With `rate_sel` = 0 the period is 2^DIV_SLOW_LOG2 (2048) cycles, and the first rising edge follows the 1024th.
- R4: Both edge sources see the same latency to the comparator. Suppose a feedback rising edge is applied just after the same clock edge on which the reference rises. The comparator then sees both edges together, and no steering pulse appears.
- R5: When each feedback edge lags its reference edge by d cycles, `phase_oe` = 1 with `phase_out` = 1 for exactly d cycles per reference period.
- R6: When each feedback edge leads its reference edge by d cycles, `phase_oe` = 1 with `phase_out` = 0 for exactly d cycles per reference period.
- R7: `phase_oe` = 0 (output released) whenever neither flag is pending.
- R8: `lock_ok` is low for exactly the cycles in which `phase_oe` is high, with no stretching.
- R9: A feedback train slower than the reference gives only drive-high pulses. A faster one, whose first edge comes before the first reference edge, gives only drive-low pulses.
- R10: Both flags are never pending together. An edge that arrives while the opposite flag is pending clears both on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; the domain of all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Divided feedback pulse train (asynchronous) |
| rate_sel | input | 1 | 1 = fast reference rate, 0 = slow reference rate |
| phase_out | output | 1 | Steering level: 1 = raise VCO, 0 = lower VCO |
| phase_oe | output | 1 | Steering output drive enable (0 = high impedance) |
| lock_ok | output | 1 | High when locked, low while a correction is pending |
| half_clk | output | 1 | Crystal clock divided by two |

## Verification
The bench places feedback edges at exact cycle offsets from the reference edges for both rates. It covers a zero offset, a lag, a lead and a single-cycle lead. A design whose synchroniser depths differ between the two paths would show a spurious pulse at zero offset or a count that is off by one. A design that stretched the lock pulse, or swapped the polarity, would show a lock-low count that does not match the enable count, or pulses on the wrong side. Free-running trains that are faster and slower than the reference catch a comparator that only looks at phase: such a design would emit pulses of both polarities.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_EDGE_SRC = 2;
  localparam int SRC_REF = 0;
  localparam int SRC_FB  = 1;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic rise_pulse
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], lvl_in};
  end

  assign rise_pulse = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/pfd_ref_prescaler.sv
module pfd_ref_prescaler #(
  parameter int DIV_FAST_LOG2 = 10,
  parameter int DIV_SLOW_LOG2 = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  output logic ref_lvl,
  output logic half_clk
);
  localparam int CW = (DIV_SLOW_LOG2 > DIV_FAST_LOG2) ? DIV_SLOW_LOG2 : DIV_FAST_LOG2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign ref_lvl  = rate_sel ? cnt[DIV_FAST_LOG2-1] : cnt[DIV_SLOW_LOG2-1];
  assign half_clk = cnt[0];
endmodule

// File: rtl/pfd_pump_core.sv
module pfd_pump_core
  import pfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_edge,
  input  logic  fb_edge,
  output pump_t pump
);
  pump_t nxt;

  always_comb begin
    nxt.up = pump.up | ref_edge;
    nxt.dn = pump.dn | fb_edge;
    if (nxt.up && nxt.dn) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pump <= '0;
    else        pump <= nxt;
  end
endmodule

// File: rtl/pfd_lock_core.sv
module pfd_lock_core
  import pfd_pkg::*;
#(
  parameter int DIV_FAST_LOG2 = 10,
  parameter int DIV_SLOW_LOG2 = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_in,
  input  logic rate_sel,
  output logic phase_out,
  output logic phase_oe,
  output logic lock_ok,
  output logic half_clk
);
  logic                    ref_lvl;
  logic [NUM_EDGE_SRC-1:0] src_lvl;
  logic [NUM_EDGE_SRC-1:0] src_rise;
  logic                    ref_edge;
  logic                    fb_edge;
  pump_t                   pump;
  logic                    pump_up;
  logic                    pump_dn;

  pfd_ref_prescaler #(
    .DIV_FAST_LOG2(DIV_FAST_LOG2),
    .DIV_SLOW_LOG2(DIV_SLOW_LOG2)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .ref_lvl  (ref_lvl),
    .half_clk (half_clk)
  );

  assign src_lvl[SRC_REF] = ref_lvl;
  assign src_lvl[SRC_FB]  = fb_in;

  for (genvar g = 0; g < NUM_EDGE_SRC; g++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_in     (src_lvl[g]),
      .rise_pulse (src_rise[g])
    );
  end

  assign ref_edge = src_rise[SRC_REF];
  assign fb_edge  = src_rise[SRC_FB];

  pfd_pump_core u_pump (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .pump     (pump)
  );

  assign pump_up   = pump.up;
  assign pump_dn   = pump.dn;
  assign phase_oe  = pump_up | pump_dn;
  assign phase_out = pump_up;
  assign lock_ok   = ~(pump_up | pump_dn);
endmodule

// File: rtl/pfd_lock_core_chk.sv
module pfd_lock_core_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_e,
  input logic fb_e,
  input logic up,
  input logic dn,
  input logic half_clk
);
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (half_clk != $past(half_clk))); // R2

  AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_e && !fb_e && !dn) |=> up); // R5

  AST_DN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_e && !ref_e && !up) |=> dn); // R6

  AST_TOGETHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_e && fb_e && !up && !dn) |=> (!up && !dn)); // R4

  AST_CROSS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((up && fb_e) || (dn && ref_e)) |=> (!up && !dn)); // R10

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn)); // R10
endmodule

bind pfd_lock_core pfd_lock_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_e    (ref_edge),
  .fb_e     (fb_edge),
  .up       (pump_up),
  .dn       (pump_dn),
  .half_clk (half_clk)
);

// File: tb/pfd_lock_core_tb.sv
`timescale 1ns/1ps
module pfd_lock_core_tb;
  localparam int NVEC = 6;
  localparam int NPER = 4;
  localparam int VSEL [NVEC] = '{1, 1, 1, 0, 0, 1};
  localparam int VLAG [NVEC] = '{0, 5, -7, 0, 12, -1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_in = 1'b0;
  logic rate_sel = 1'b1;
  logic phase_out, phase_oe, lock_ok, half_clk;

  int n_chk = 0;
  int n_fail = 0;
  int cnt_up, cnt_dn, cnt_low, hc1, hc2;

  always #2.5 clk = ~clk;

  pfd_lock_core u_dut (
    .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .rate_sel(rate_sel),
    .phase_out(phase_out), .phase_oe(phase_oe), .lock_ok(lock_ok), .half_clk(half_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0; fb_in = 1'b0; rate_sel = sel;
    repeat (3) @(negedge clk);
    chk(phase_oe == 1'b0, "R1 phase_oe in reset", int'(phase_oe), 0);
    chk(lock_ok == 1'b1, "R1 lock_ok in reset", int'(lock_ok), 1);
    chk(half_clk == 1'b0, "R1 half_clk in reset", int'(half_clk), 0);
    rst_n = 1'b1;
  endtask

  // Feedback pulses of 4 cycles starting at cycle 'first' every 'per' cycles
  task automatic run_case(input int first, input int per, input int win);
    cnt_up = 0; cnt_dn = 0; cnt_low = 0;
    for (int cyc = 1; cyc <= win; cyc++) begin
      @(posedge clk);
      #1;
      fb_in = (cyc >= first) && (((cyc - first) % per) < 4);
      @(negedge clk);
      if (cyc == 1) hc1 = int'(half_clk);
      if (cyc == 2) hc2 = int'(half_clk);
      if (phase_oe && phase_out)  cnt_up++;
      if (phase_oe && !phase_out) cnt_dn++;
      if (!lock_ok)               cnt_low++;
    end
    fb_in = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // Table walk: equal-rate trains with a fixed cycle offset (R3..R8)
    for (int v = 0; v < NVEC; v++) begin
      int per, first_ref, exp_up, exp_dn;
      per       = (VSEL[v] == 1) ? 1024 : 2048;
      first_ref = per / 2;
      exp_up    = (VLAG[v] > 0) ? NPER * VLAG[v] : 0;
      exp_dn    = (VLAG[v] < 0) ? -NPER * VLAG[v] : 0;
      do_reset(VSEL[v][0]);
      run_case(first_ref + VLAG[v], per, first_ref + 3 * per + per / 2);
      chk(cnt_up == exp_up, "R5 drive-high cycles (R3 R4)", cnt_up, exp_up);
      chk(cnt_dn == exp_dn, "R6 drive-low cycles (R3 R4)", cnt_dn, exp_dn);
      chk(cnt_low == cnt_up + cnt_dn, "R8 lock-low equals enable cycles (R7)", cnt_low, cnt_up + cnt_dn);
      if (v == 0) begin
        chk(hc1 == 1, "R2 half_clk after first edge", hc1, 1);
        chk(hc2 == 0, "R2 half_clk after second edge", hc2, 0);
      end
    end

    // Directed: feedback slower than reference (R9)
    do_reset(1'b1);
    run_case(600, 1536, 6000);
    chk(cnt_dn == 0, "R9 slower feedback gives no drive-low", cnt_dn, 0);
    chk(cnt_up > 0, "R9 slower feedback gives drive-high", cnt_up, 1);
    chk(cnt_low == cnt_up + cnt_dn, "R8 lock-low slower case", cnt_low, cnt_up + cnt_dn);

    // Directed: feedback faster than reference (R9)
    do_reset(1'b1);
    run_case(400, 768, 6000);
    chk(cnt_up == 0, "R9 faster feedback gives no drive-high", cnt_up, 0);
    chk(cnt_dn > 0, "R9 faster feedback gives drive-low", cnt_dn, 1);
    chk(cnt_low == cnt_up + cnt_dn, "R8 lock-low faster case", cnt_low, cnt_up + cnt_dn);

    // Directed: rate select moves the first reference edge (R3): lag 3 at slow rate
    do_reset(1'b0);
    run_case(1024 + 3, 2048, 1024 + 2048 / 2);
    chk(cnt_up == 3, "R3 slow-rate first reference edge position", cnt_up, 3);
    chk(cnt_dn == 0, "R10 no opposite pulse", cnt_dn, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule